// File: doc/BRIEF.md
# Chunked Media Read Buffer

This block sits between a host that reads in 64-byte pieces and a slow storage medium whose internal access unit is 256 bytes. When a host read finds no copy of its 256-byte unit in the buffer, the block fetches the whole unit from the medium. It returns the requested 64-byte slice and keeps the full unit in one of 64 entries, so the buffer holds 16 KB. Any later read of a slice in a resident unit is served from the buffer after a short fixed delay (`HIT_LAT`). The medium's own latency is much longer; the bench uses 9 cycles against a 4-cycle hit.

The buffer is fully associative: any unit may sit in any entry. Each entry holds a valid bit and a tag, which is the address above bit 7. A miss replaces the least recently used entry, and both hits and fills make the touched entry the most recent. The block handles one host read at a time, so at most one medium fetch is ever outstanding. A read of a unit that is being fetched cannot start a second fetch: it waits until the fill is done and then hits.

The controller has five states. `ST_IDLE` accepts a request. It goes to `ST_HIT` when the lookup hits and to `ST_ISSUE` when it misses. `ST_HIT` counts out the hit delay and then goes to `ST_RESP`. `ST_ISSUE` drives the one-cycle medium request and goes to `ST_WAIT`. `ST_WAIT` stays until the medium answers; it then fills the victim entry and goes to `ST_RESP`. `ST_RESP` presents the response for one cycle and returns to `ST_IDLE`.

Top module: `media_read_buf`

## Requirements
- R1: After reset every entry is invalid, `req_ready` is 1, and `rsp_valid` and `med_req_valid` are 0. The first read after reset is a miss.
- R2: On a miss, `med_req_valid` is high for exactly one cycle, in the cycle after acceptance. `med_req_unit` carries `req_addr[ADDR_W-1:8]`. The response rises one cycle after `med_rsp_valid`, with `rsp_hit` = 0. With a medium that answers MED_LAT edges after it samples the request, this is MED_LAT+2 edges after acceptance.
- R3: On a hit, no medium request is made. `rsp_valid` rises exactly `HIT_LAT` edges after the acceptance edge, with `rsp_hit` = 1.
- R4: `rsp_data` is the 64-byte slice of the unit selected by `req_addr[7:6]`. Slice k occupies bits [512k+511:512k] of the 2048-bit unit. This holds for hits and misses, whichever slice arrives first.
- R5: A stream of consecutive 64-byte reads gives one miss followed by three hits, repeating. Each miss falls on a 256-byte-aligned address.
- R6: Any 64 distinct units can be resident together, including units that differ only in high address bits. After they are loaded, a read of each one hits.
- R7: A miss with all entries valid evicts the least recently used unit. A hit or a fill makes its unit the most recently used.
- R8: Only one request is in flight. `req_ready` is low from acceptance until the cycle after the one-cycle `rsp_valid` pulse. `med_rsp_valid` seen outside a pending fetch has no effect on the buffer contents.
- R9: `req_addr[5:0]` has no effect on hit detection or on the returned data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W (34) | Host byte address |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Response was served from the buffer |
| rsp_data | output | 512 | Returned 64-byte slice |
| med_req_valid | output | 1 | Medium fetch request (one cycle) |
| med_req_unit | output | ADDR_W-8 (26) | 256-byte unit index to fetch |
| med_rsp_valid | input | 1 | Medium returns a unit |
| med_rsp_data | input | 2048 | Fetched 256-byte unit |

## Verification
The bench keeps an ordered list of resident units as its replacement model. It compares every response's hit flag, latency, slice and medium traffic against that model, so a design that picks the most recently used entry as victim, or that forgets to refresh recency on a hit, mispredicts a later hit or miss. Several streams target specific faults. Units that differ only in their top bits expose a truncated tag as false hits. Slices read out of order within a unit expose a wrong slice select as data mismatches, and a design that skips the fetch on a non-aligned first access fails there too. A stray medium strobe while idle would, in a design that fills outside a pending fetch, corrupt a resident entry, and the next hit's data shows it.

// File: rtl/mrb_pkg.sv
package mrb_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_HIT,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } mrb_state_e;
endpackage

// File: rtl/mrb_tag_array.sv
module mrb_tag_array #(
    parameter int ENTRIES = 64,
    parameter int TAG_W   = 26,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag
);
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] match;
    logic [TAG_W-1:0]   tags [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
            end else if (fill_en && fill_idx == IDX_W'(i)) begin
                vld[i] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_idx == IDX_W'(i)) begin
                tags[i] <= fill_tag;
            end
        end

        assign match[i] = vld[i] && (tags[i] == lk_tag);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

    AST_TAG_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(match)); // R6
endmodule

// File: rtl/mrb_lru.sv
module mrb_lru #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);
    logic [IDX_W-1:0]   rank [ENTRIES];
    logic [ENTRIES-1:0] oldest;
    logic [IDX_W-1:0]   touched_rank;

    assign touched_rank = rank[touch_idx];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_rank
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank[i] <= IDX_W'(i);
            end else if (touch_en) begin
                if (touch_idx == IDX_W'(i)) begin
                    rank[i] <= '0;
                end else if (rank[i] < touched_rank) begin
                    rank[i] <= rank[i] + 1'b1;
                end
            end
        end

        assign oldest[i] = (rank[i] == IDX_W'(ENTRIES - 1));
    end

    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (oldest[i]) victim_idx = IDX_W'(i);
        end
    end

    AST_LRU_ONE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n) $onehot(oldest)); // R7
endmodule

// File: rtl/mrb_data_store.sv
module mrb_data_store #(
    parameter int ENTRIES = 64,
    parameter int UNIT_W  = 2048,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [UNIT_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [UNIT_W-1:0] rd_data
);
    logic [UNIT_W-1:0] mem [ENTRIES];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];
endmodule

// File: rtl/media_read_buf.sv
module media_read_buf
    import mrb_pkg::*;
#(
    parameter int ADDR_W     = 34,
    parameter int HOST_BYTES = 64,
    parameter int UNIT_BYTES = 256,
    parameter int ENTRIES    = 64,
    parameter int HIT_LAT    = 4,
    localparam int HOST_W    = HOST_BYTES * 8,
    localparam int UNIT_W    = UNIT_BYTES * 8,
    localparam int OFS_LSB   = $clog2(HOST_BYTES),
    localparam int TAG_LSB   = $clog2(UNIT_BYTES),
    localparam int TAG_W     = ADDR_W - TAG_LSB,
    localparam int SEL_W     = TAG_LSB - OFS_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [HOST_W-1:0] rsp_data,
    output logic              med_req_valid,
    output logic [TAG_W-1:0]  med_req_unit,
    input  logic              med_rsp_valid,
    input  logic [UNIT_W-1:0] med_rsp_data
);
    localparam int IDX_W = $clog2(ENTRIES);
    localparam int CNT_W = $clog2(HIT_LAT);

    mrb_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_q;
    logic [SEL_W-1:0]  sel_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HOST_W-1:0] rsp_data_q;
    logic              rsp_hit_q;

    logic [TAG_W-1:0]  lk_tag;
    logic [SEL_W-1:0]  lk_sel;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  victim_idx;
    logic [UNIT_W-1:0] store_rd;
    logic              accept;
    logic              fill;
    logic              touch_en;
    logic [IDX_W-1:0]  touch_idx;

    assign lk_tag    = req_addr[ADDR_W-1:TAG_LSB];
    assign lk_sel    = req_addr[TAG_LSB-1:OFS_LSB];
    assign accept    = req_valid && (state_q == ST_IDLE);
    assign fill      = (state_q == ST_WAIT) && med_rsp_valid;
    assign touch_en  = (accept && hit) || fill;
    assign touch_idx = fill ? victim_idx : hit_idx;

    mrb_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_tag   (lk_tag),
        .hit      (hit),
        .hit_idx  (hit_idx),
        .fill_en  (fill),
        .fill_idx (victim_idx),
        .fill_tag (tag_q)
    );

    mrb_lru #(.ENTRIES(ENTRIES)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (victim_idx)
    );

    mrb_data_store #(.ENTRIES(ENTRIES), .UNIT_W(UNIT_W)) u_store (
        .clk     (clk),
        .wr_en   (fill),
        .wr_idx  (victim_idx),
        .wr_data (med_rsp_data),
        .rd_idx  (hit_idx),
        .rd_data (store_rd)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = hit ? ST_HIT : ST_ISSUE;
            ST_HIT:   if (cnt_q == CNT_W'(HIT_LAT - 1)) state_d = ST_RESP;
            ST_ISSUE: state_d = ST_WAIT;
            ST_WAIT:  if (med_rsp_valid) state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            tag_q      <= '0;
            sel_q      <= '0;
            rsp_hit_q  <= 1'b0;
            rsp_data_q <= '0;
        end else begin
            if (accept) begin
                cnt_q     <= '0;
                tag_q     <= lk_tag;
                sel_q     <= lk_sel;
                rsp_hit_q <= hit;
                if (hit) rsp_data_q <= store_rd[HOST_W*int'(lk_sel) +: HOST_W];
            end else if (state_q == ST_HIT) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (fill) rsp_data_q <= med_rsp_data[HOST_W*int'(sel_q) +: HOST_W];
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_valid     = (state_q == ST_RESP);
    assign rsp_hit       = rsp_hit_q;
    assign rsp_data      = rsp_data_q;
    assign med_req_valid = (state_q == ST_ISSUE);
    assign med_req_unit  = tag_q;

    AST_FETCH_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) med_req_valid |=> !med_req_valid); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> (!rsp_valid && req_ready)); // R8
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (!rst_n) accept |=> !req_ready); // R8
    AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (accept && hit) |=> !med_req_valid); // R3
    AST_MISS_FETCH: assert property (@(posedge clk) disable iff (!rst_n) (accept && !hit) |=> (med_req_valid && med_req_unit == $past(lk_tag))); // R2
endmodule

// File: tb/media_read_buf_tb.sv
module media_read_buf_tb;
    localparam int ADDR_W  = 34;
    localparam int ENTRIES = 64;
    localparam int HIT_LAT = 4;
    localparam int MED_LAT = 9;
    localparam int HOST_W  = 512;
    localparam int UNIT_W  = 2048;
    localparam int TAG_W   = ADDR_W - 8;
    localparam int WORDS   = UNIT_W / 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic              rsp_hit;
    logic [HOST_W-1:0] rsp_data;
    logic              med_req_valid;
    logic [TAG_W-1:0]  med_req_unit;
    logic              med_rsp_valid;
    logic [UNIT_W-1:0] med_rsp_data;

    int vectors = 0;
    int fails   = 0;
    int fetches = 0;
    logic [TAG_W-1:0] last_unit = '0;
    logic [TAG_W-1:0] lru_q [$];

    always #2 clk = ~clk;

    media_read_buf u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_hit       (rsp_hit),
        .rsp_data      (rsp_data),
        .med_req_valid (med_req_valid),
        .med_req_unit  (med_req_unit),
        .med_rsp_valid (med_rsp_valid),
        .med_rsp_data  (med_rsp_data)
    );

    function automatic logic [UNIT_W-1:0] make_unit(logic [TAG_W-1:0] u);
        logic [UNIT_W-1:0] r;
        for (int w = 0; w < WORDS; w++) r[w*32 +: 32] = 32'(u) * 32'(WORDS) + 32'(w);
        return r;
    endfunction

    // medium model
    int                med_cnt = 0;
    logic [TAG_W-1:0]  med_unit = '0;
    logic              med_v = 1'b0;
    logic [UNIT_W-1:0] med_d = '0;
    logic              spur = 1'b0;

    always @(posedge clk) begin
        med_v <= 1'b0;
        if (med_cnt > 0) begin
            med_cnt <= med_cnt - 1;
            if (med_cnt == 1) begin
                med_v <= 1'b1;
                med_d <= make_unit(med_unit);
            end
        end else if (rst_n && med_req_valid) begin
            med_cnt  <= MED_LAT;
            med_unit <= med_req_unit;
        end
    end

    assign med_rsp_valid = med_v | spur;
    assign med_rsp_data  = spur ? '1 : med_d;

    always @(posedge clk) begin
        if (rst_n && med_req_valid) begin
            fetches++;
            last_unit = med_req_unit;
        end
    end

    task automatic check(bit ok, string rq, logic [63:0] act, logic [63:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, string hit_rq);
        logic [TAG_W-1:0]  unit = a[ADDR_W-1:8];
        int                sel  = int'(a[7:6]);
        int                pos  = -1;
        bit                exp_hit;
        int                f0;
        int                lat  = 0;
        bit                busy_ok = 1'b1;
        int                exp_lat;
        logic [HOST_W-1:0] exp_data;
        logic [UNIT_W-1:0] full;
        foreach (lru_q[i]) if (lru_q[i] == unit) pos = i;
        exp_hit = (pos >= 0);
        if (exp_hit) lru_q.delete(pos);
        lru_q.push_front(unit);
        if (lru_q.size() > ENTRIES) void'(lru_q.pop_back());
        full     = make_unit(unit);
        exp_data = full[HOST_W*sel +: HOST_W];
        exp_lat  = exp_hit ? HIT_LAT : MED_LAT + 2;

        @(negedge clk);
        while (!req_ready) @(negedge clk);
        f0 = fetches;
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && lat < 200) begin
            @(negedge clk);
            lat++;
            vectors++;
            if (req_ready) busy_ok = 1'b0;
        end
        check(lat == exp_lat, exp_hit ? "R3 latency" : "R2 latency", 64'(lat), 64'(exp_lat));
        check(rsp_hit == exp_hit, hit_rq, 64'(rsp_hit), 64'(exp_hit));
        check(rsp_data == exp_data, "R4 data", rsp_data[63:0], exp_data[63:0]);
        check((fetches - f0) == (exp_hit ? 0 : 1), "R2 fetch count", 64'(fetches - f0), exp_hit ? 64'd0 : 64'd1);
        if (!exp_hit) check(last_unit == unit, "R2 fetch unit", 64'(last_unit), 64'(unit));
        check(busy_ok, "R8 ready low while busy", 64'(busy_ok), 64'd1);
    endtask

    function automatic logic [ADDR_W-1:0] mk_addr(logic [TAG_W-1:0] u, int sel);
        return {u, 2'(sel), 6'h0};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [TAG_W-1:0] snap [$];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        check(rsp_valid == 1'b0, "R1 rsp idle after reset", 64'(rsp_valid), 64'd0);
        check(med_req_valid == 1'b0, "R1 no fetch after reset", 64'(med_req_valid), 64'd0);

        // R1: first read misses
        do_read(mk_addr(0, 0), "R1 first read misses");

        // R5: sequential stream
        for (int i = 1; i < 32; i++) do_read(ADDR_W'(i * 64), "R5 stream hit/miss");

        // R9: low address bits ignored
        do_read(mk_addr(0, 2) | ADDR_W'(6'h25), "R9 low bits ignored");
        do_read(mk_addr(3, 1) | ADDR_W'(6'h3F), "R9 low bits ignored");

        // R4: slices out of order, first access not aligned
        do_read(mk_addr(100, 3), "R4 unaligned first miss");
        do_read(mk_addr(100, 1), "R4 slice order");
        do_read(mk_addr(100, 2), "R4 slice order");
        do_read(mk_addr(100, 0), "R4 slice order");

        // R6: fill to 64 units, many differing only in high bits
        for (int i = 0; i < 55; i++)
            do_read(mk_addr(TAG_W'((1 << 25) | (i * 4099)), i % 4), "R6 load");
        check(lru_q.size() == ENTRIES, "R6 model full", 64'(lru_q.size()), 64'(ENTRIES));
        do_read(mk_addr(TAG_W'(1 << 25), 1), "R6 high-bit alias resident");
        snap = lru_q;
        foreach (snap[i]) do_read(mk_addr(snap[i], i % 4), "R6 all resident");

        // R7: LRU eviction with recency refresh
        do_read(mk_addr(200, 0), "R7 evict oldest");
        do_read(mk_addr(snap[0], 0), "R7 evicted unit misses");
        for (int i = 0; i < 60; i++)
            do_read(mk_addr(TAG_W'(300 + (i * 37) % 80), i % 4), "R7 replacement order");
        for (int i = 0; i < 20; i++)
            do_read(mk_addr(TAG_W'(300 + (i * 11) % 90), 3 - i % 4), "R7 replacement order");

        // R8: stray medium strobe while idle
        @(negedge clk);
        spur = 1'b1;
        @(negedge clk);
        spur = 1'b0;
        snap = lru_q;
        foreach (snap[i]) if (i < 8) do_read(mk_addr(snap[i], 2), "R8 stray strobe ignored");
        // R8: back-to-back read of just-fetched unit hits
        do_read(mk_addr(5000, 1), "R8 fetch then reread");
        do_read(mk_addr(5000, 2), "R8 fetch then reread");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule